// File: doc/BRIEF.md
# Pilot-Driven Subcarrier Bit Loader

This receive-side block runs during link training of a multi-tone link. The far end transmits a known QPSK pilot on every subcarrier, and this block takes in the received frequency-domain bins. It regenerates the expected pilot point locally and sums the squared error vector for each subcarrier over a programmable run of symbols. It then averages the sum and turns it into a bit count between 0 and 6 by comparing it against six programmable thresholds.

The finished allocation table is streamed out in subcarrier order so that it can be returned to the transmitter. Two subcarriers are reserved for the link channel. These are never loaded from measurement and always report a fixed count.

Bins enter on a valid/ready stream. The block holds `bin_ready` low whenever it is not collecting, and a bin counts only in a cycle where both `bin_valid` and `bin_ready` are high. The table leaves on a second valid/ready stream. While `out_ready` is low, the current entry holds steady. Control (`start`, `busy`, `done`) and the threshold write port are plain level signals.

Top module: `evm_bit_loader`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy`, `done`, `bin_ready` and `out_valid` are low.
- R2: A `start` pulse taken while `busy` is low does three things: it clears every subcarrier accumulator, it reseeds the pilot generator, and it raises `busy`. `bin_ready` is high only while bins are being collected.
- R3: A `start` pulse seen while `busy` is high has no effect. The run in progress continues with its original averaging setting and its accumulated sums.
- R4: The pilot generator is a 15-bit shift register seeded with all ones. For each accepted bin, state bit 0 selects the I sign and state bit 1 selects the Q sign (1 gives +PILOT_AMP, 0 gives -PILOT_AMP). The register then steps to {s[13:0], s[14]^s[13]}.
- R5: Each accepted bin adds (I-refI)^2+(Q-refQ)^2 to the accumulator of its `bin_idx`. A symbol ends on an accepted bin with index NUM_SC-1. After 2^N symbols collection stops. N is `avg_shift` sampled at start, with any value above 6 taken as 6.
- R6: The average is the sum shifted right by N. The entry equals the number of thresholds k (0..5) with average <= threshold k, so equality earns the higher count. Thresholds are written through `thr_we`/`thr_sel`/`thr_wdata`, and select values of 6 and above are dropped.
- R7: The subcarriers at LINK_A and LINK_B always report LINK_BITS.
- R8: `done` rises only after every subcarrier has been classified and `busy` has fallen. It stays high until the next accepted start. `busy` and `done` are never both high.
- R9: The table is streamed once, with `out_idx` running from 0 to NUM_SC-1 and `out_last` marking the final entry. An entry stays stable while `out_valid` is high and `out_ready` is low, and every entry is at most 6.
- R10: Bins offered while the block is idle or done are not accepted and do not enter any later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a training run |
| avg_shift | input | 3 | log2 of symbols to average (clamped to 6) |
| busy | output | 1 | Collecting or classifying |
| done | output | 1 | Table ready |
| thr_we | input | 1 | Threshold write strobe |
| thr_sel | input | 3 | Threshold number 0..5 |
| thr_wdata | input | 2*DW+2 | Threshold value |
| bin_valid | input | 1 | Bin offered |
| bin_ready | output | 1 | Bin accepted when high with valid |
| bin_idx | input | clog2(NUM_SC) | Subcarrier of the bin |
| bin_i | input | DW | Received in-phase value, signed |
| bin_q | input | DW | Received quadrature value, signed |
| out_valid | output | 1 | Table entry offered |
| out_ready | input | 1 | Consumer takes entry |
| out_idx | output | clog2(NUM_SC) | Subcarrier of entry |
| out_bits | output | 3 | Allocated bits 0..6 |
| out_last | output | 1 | Final entry of table |

## Verification
The properties check the following on every cycle: readout entries stay bounded and steady under back-pressure, indices step upward after each handshake, the reserved subcarriers report their fixed value, `busy` and `done` exclude each other, and `bin_ready` never rises outside a run. Other behaviour only the scenarios can show. These are the actual per-subcarrier counts from pilot error, equality at a threshold, the shift clamp, the discarding of a start sent mid-run, and the fact that bins offered while idle leave later tables untouched. Each of these is checked against a model of the pilot sequence and error sums kept in the bench.

// File: rtl/evm_load_pkg.sv
package evm_load_pkg;
  localparam int NUM_THR   = 6;
  localparam int MAX_SHIFT = 6;
  localparam int PRBS_W    = 15;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_GRADE,
    ST_STREAM
  } load_state_t;

  function automatic logic [PRBS_W-1:0] prbs_step(input logic [PRBS_W-1:0] s);
    return {s[PRBS_W-2:0], s[PRBS_W-1] ^ s[PRBS_W-2]};
  endfunction
endpackage

// File: rtl/pilot_ref_gen.sv
module pilot_ref_gen #(
  parameter int DW        = 10,
  parameter int PILOT_AMP = 96
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reseed,
  input  logic                 advance,
  output logic signed [DW-1:0] ref_i,
  output logic signed [DW-1:0] ref_q
);
  import evm_load_pkg::*;

  localparam logic signed [DW-1:0] POS = DW'(PILOT_AMP);
  localparam logic signed [DW-1:0] NEG = -DW'(PILOT_AMP);

  logic [PRBS_W-1:0] lfsr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lfsr_q <= '1;
    else if (reseed)  lfsr_q <= '1;
    else if (advance) lfsr_q <= prbs_step(lfsr_q);
  end

  assign ref_i = lfsr_q[0] ? POS : NEG;
  assign ref_q = lfsr_q[1] ? POS : NEG;
endmodule

// File: rtl/evm_err_sq.sv
module evm_err_sq #(
  parameter int DW  = 10,
  parameter int SQW = 2*DW+2
) (
  input  logic signed [DW-1:0] rx_i,
  input  logic signed [DW-1:0] rx_q,
  input  logic signed [DW-1:0] ref_i,
  input  logic signed [DW-1:0] ref_q,
  output logic        [SQW-1:0] err_sq
);
  logic signed [DW:0]    d_i, d_q;
  logic signed [SQW-1:0] w_i, w_q;

  always_comb begin
    d_i = {rx_i[DW-1], rx_i} - {ref_i[DW-1], ref_i};
    d_q = {rx_q[DW-1], rx_q} - {ref_q[DW-1], ref_q};
    w_i = {{(SQW-DW-1){d_i[DW]}}, d_i};
    w_q = {{(SQW-DW-1){d_q[DW]}}, d_q};
    err_sq = SQW'(w_i * w_i) + SQW'(w_q * w_q);
  end
endmodule

// File: rtl/evm_bit_classify.sv
module evm_bit_classify #(
  parameter int SQW       = 22,
  parameter int NUM_THR   = 6,
  parameter int LINK_BITS = 2
) (
  input  logic [SQW-1:0]              avg,
  input  logic [NUM_THR-1:0][SQW-1:0] thr,
  input  logic                        is_link,
  output logic [2:0]                  bits
);
  logic [NUM_THR-1:0] pass;

  for (genvar k = 0; k < NUM_THR; k++) begin : g_cmp
    assign pass[k] = (avg <= thr[k]);
  end

  always_comb begin
    bits = '0;
    for (int k = 0; k < NUM_THR; k++) bits = bits + 3'(pass[k]);
    if (is_link) bits = 3'(LINK_BITS);
  end
endmodule

// File: rtl/evm_bit_loader.sv
module evm_bit_loader #(
  parameter int NUM_SC    = 256,
  parameter int DW        = 10,
  parameter int PILOT_AMP = 96,
  parameter int LINK_A    = 64,
  parameter int LINK_B    = 192,
  parameter int LINK_BITS = 2,
  localparam int IDXW     = $clog2(NUM_SC),
  localparam int SQW      = 2*DW+2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      avg_shift,
  output logic            busy,
  output logic            done,
  input  logic            thr_we,
  input  logic [2:0]      thr_sel,
  input  logic [SQW-1:0]  thr_wdata,
  input  logic            bin_valid,
  output logic            bin_ready,
  input  logic [IDXW-1:0] bin_idx,
  input  logic [DW-1:0]   bin_i,
  input  logic [DW-1:0]   bin_q,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [IDXW-1:0] out_idx,
  output logic [2:0]      out_bits,
  output logic            out_last
);
  import evm_load_pkg::*;

  localparam int ACCW = SQW + MAX_SHIFT;
  localparam int SYMW = MAX_SHIFT + 1;
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NUM_SC-1);

  load_state_t             state_q;
  logic [2:0]              shift_q;
  logic [SYMW-1:0]         sym_q;
  logic [IDXW-1:0]         scan_q, rd_q;
  logic                    rd_end_q;
  logic [ACCW-1:0]         acc_q [NUM_SC];
  logic [2:0]              tbl_q [NUM_SC];
  logic [NUM_THR-1:0][SQW-1:0] thr_q;

  logic                    go, accept, sym_last;
  logic signed [DW-1:0]    ref_i, ref_q;
  logic [SQW-1:0]          err_sq, avg;
  logic [2:0]              grade_bits;

  assign busy      = (state_q == ST_COLLECT) || (state_q == ST_GRADE);
  assign done      = (state_q == ST_STREAM);
  assign bin_ready = (state_q == ST_COLLECT);
  assign go        = start && !busy;
  assign accept    = bin_valid && bin_ready;
  assign sym_last  = (sym_q == ((SYMW'(1) << shift_q) - SYMW'(1)));

  pilot_ref_gen #(.DW(DW), .PILOT_AMP(PILOT_AMP)) u_ref (
    .clk(clk), .rst_n(rst_n), .reseed(go), .advance(accept),
    .ref_i(ref_i), .ref_q(ref_q)
  );

  evm_err_sq #(.DW(DW), .SQW(SQW)) u_sq (
    .rx_i(bin_i), .rx_q(bin_q), .ref_i(ref_i), .ref_q(ref_q), .err_sq(err_sq)
  );

  assign avg = SQW'(acc_q[scan_q] >> shift_q);

  evm_bit_classify #(.SQW(SQW), .NUM_THR(NUM_THR), .LINK_BITS(LINK_BITS)) u_cls (
    .avg(avg), .thr(thr_q),
    .is_link((scan_q == IDXW'(LINK_A)) || (scan_q == IDXW'(LINK_B))),
    .bits(grade_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= '0;
    else if (thr_we && (thr_sel < 3'(NUM_THR))) thr_q[thr_sel] <= thr_wdata;
  end

  always_ff @(posedge clk) begin
    if (go) begin
      for (int s = 0; s < NUM_SC; s++) acc_q[s] <= '0;
    end else if (accept && (int'(bin_idx) < NUM_SC)) begin
      acc_q[bin_idx] <= acc_q[bin_idx] + ACCW'(err_sq);
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == ST_GRADE) tbl_q[scan_q] <= grade_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      shift_q  <= '0;
      sym_q    <= '0;
      scan_q   <= '0;
      rd_q     <= '0;
      rd_end_q <= 1'b0;
    end else if (go) begin
      state_q  <= ST_COLLECT;
      shift_q  <= (avg_shift > 3'(MAX_SHIFT)) ? 3'(MAX_SHIFT) : avg_shift;
      sym_q    <= '0;
    end else begin
      unique case (state_q)
        ST_COLLECT: if (accept && bin_idx == LAST_IDX) begin
          if (sym_last) begin
            state_q <= ST_GRADE;
            scan_q  <= '0;
          end else begin
            sym_q <= sym_q + SYMW'(1);
          end
        end
        ST_GRADE: begin
          if (scan_q == LAST_IDX) begin
            state_q  <= ST_STREAM;
            rd_q     <= '0;
            rd_end_q <= 1'b0;
          end else begin
            scan_q <= scan_q + IDXW'(1);
          end
        end
        ST_STREAM: if (out_valid && out_ready) begin
          if (rd_q == LAST_IDX) rd_end_q <= 1'b1;
          else                  rd_q     <= rd_q + IDXW'(1);
        end
        default: ;
      endcase
    end
  end

  assign out_valid = (state_q == ST_STREAM) && !rd_end_q;
  assign out_idx   = rd_q;
  assign out_bits  = tbl_q[rd_q];
  assign out_last  = (rd_q == LAST_IDX);
endmodule

// File: rtl/evm_bit_loader_chk.sv
module evm_bit_loader_chk #(
  parameter int NUM_SC    = 256,
  parameter int LINK_A    = 64,
  parameter int LINK_B    = 192,
  parameter int LINK_BITS = 2,
  localparam int IDXW     = $clog2(NUM_SC)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            bin_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [IDXW-1:0] out_idx,
  input logic [2:0]      out_bits,
  input logic            out_last
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && !bin_ready && !out_valid));

  p_ready_in_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bin_ready |-> busy);

  p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  p_bits_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bits <= 3'd6));

  p_link_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_idx == IDXW'(LINK_A) || out_idx == IDXW'(LINK_B)))
      |-> (out_bits == 3'(LINK_BITS)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_idx) && $stable(out_bits)));

  p_ascend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> (out_valid && out_idx == $past(out_idx) + IDXW'(1)));
endmodule

bind evm_bit_loader evm_bit_loader_chk #(
  .NUM_SC(NUM_SC), .LINK_A(LINK_A), .LINK_B(LINK_B), .LINK_BITS(LINK_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .bin_ready(bin_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx),
  .out_bits(out_bits), .out_last(out_last)
);

// File: tb/evm_bit_loader_tb_top.sv
module evm_bit_loader_tb_top;
  localparam int NUM_SC = 16;
  localparam int DW     = 10;
  localparam int AMP    = 96;
  localparam int LA     = 3;
  localparam int LB     = 12;
  localparam int LBITS  = 2;
  localparam int IDXW   = $clog2(NUM_SC);
  localparam int SQW    = 2*DW+2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, thr_we = 0, bin_valid = 0, out_ready = 0;
  logic [2:0] avg_shift = 0, thr_sel = 0;
  logic [SQW-1:0] thr_wdata = 0;
  logic [IDXW-1:0] bin_idx = 0;
  logic [DW-1:0] bin_i = 0, bin_q = 0;
  logic busy, done, bin_ready, out_valid, out_last;
  logic [IDXW-1:0] out_idx;
  logic [2:0] out_bits;

  int errors = 0, checks = 0;
  longint macc [NUM_SC];
  longint thr_m [6];
  logic [14:0] lfsr_m;
  int noise_m [NUM_SC];

  always #2.5 clk = ~clk;

  evm_bit_loader #(.NUM_SC(NUM_SC), .DW(DW), .PILOT_AMP(AMP),
                   .LINK_A(LA), .LINK_B(LB), .LINK_BITS(LBITS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .avg_shift(avg_shift),
    .busy(busy), .done(done), .thr_we(thr_we), .thr_sel(thr_sel),
    .thr_wdata(thr_wdata), .bin_valid(bin_valid), .bin_ready(bin_ready),
    .bin_idx(bin_idx), .bin_i(bin_i), .bin_q(bin_q), .out_valid(out_valid),
    .out_ready(out_ready), .out_idx(out_idx), .out_bits(out_bits),
    .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_bits(input int sc, input int n);
    longint avg;
    int b;
    if (sc == LA || sc == LB) return LBITS;
    avg = macc[sc] >>> n;
    b = 0;
    for (int k = 0; k < 6; k++) if (avg <= thr_m[k]) b++;
    return b;
  endfunction

  function automatic int dir_err(input int sc);
    case (sc)
      0: return 0;   1: return 4;   2: return 5;   3: return 10;
      4: return 11;  5: return 20;  6: return 21;  7: return 30;
      8: return 31;  9: return 40;  10: return 41; 11: return 50;
      12: return 51; 13: return 60; 14: return 3;  default: return 2;
    endcase
  endfunction

  task automatic write_thr(input int k, input longint v);
    @(negedge clk);
    thr_we = 1; thr_sel = 3'(k); thr_wdata = SQW'(v);
    if (k < 6) thr_m[k] = v;
    @(negedge clk);
    thr_we = 0;
  endtask

  task automatic send_bin(input int sc, input int ei, input int eq);
    int ri, rq;
    ri = lfsr_m[0] ? AMP : -AMP;
    rq = lfsr_m[1] ? AMP : -AMP;
    if ($urandom_range(0, 4) == 0) begin
      @(negedge clk); bin_valid = 0;
    end
    forever begin
      @(negedge clk);
      bin_valid = 1; bin_idx = IDXW'(sc);
      bin_i = DW'(ri + ei); bin_q = DW'(rq + eq);
      if (bin_ready) break;
    end
    macc[sc] += longint'(ei*ei + eq*eq);
    lfsr_m = {lfsr_m[13:0], lfsr_m[14] ^ lfsr_m[13]};
  endtask

  // mode 0: random noise per subcarrier; mode 1: directed I error
  task automatic run(input int shift_in, input int mode, input bit inject, input string tag);
    int n, nsym, got, wd;
    n = (shift_in > 6) ? 6 : shift_in;
    nsym = 1 << n;
    for (int s = 0; s < NUM_SC; s++) begin
      macc[s] = 0;
      noise_m[s] = $urandom_range(0, 60);
    end
    @(negedge clk);
    start = 1; avg_shift = 3'(shift_in);
    @(negedge clk);
    start = 0;
    lfsr_m = '1;
    check(busy === 1'b1 && done === 1'b0, "R2 busy after start", busy, 1);
    for (int y = 0; y < nsym; y++) begin
      for (int sc = 0; sc < NUM_SC; sc++) begin
        int ei, eq;
        if (inject && y == 0 && sc == 5) begin
          @(negedge clk);
          bin_valid = 0; start = 1; avg_shift = 3'd0;
          @(negedge clk);
          start = 0;
          check(busy === 1'b1, "R3 start ignored while busy", busy, 1);
        end
        if (mode == 1) begin ei = dir_err(sc); eq = 0; end
        else begin
          ei = int'($urandom_range(0, 2*noise_m[sc])) - noise_m[sc];
          eq = int'($urandom_range(0, 2*noise_m[sc])) - noise_m[sc];
        end
        if (y == nsym-1 && sc == NUM_SC-1)
          check(done === 1'b0 && bin_ready === 1'b1, "R5 still collecting before final bin", done, 0);
        send_bin(sc, ei, eq);
      end
    end
    @(negedge clk);
    bin_valid = 0;
    wd = 0;
    while (!done && wd < 1000) begin @(negedge clk); wd++; end
    check(done === 1'b1 && busy === 1'b0, {"R8 done after grading ", tag}, done, 1);
    got = 0; wd = 0;
    while (got < NUM_SC && wd < 5000) begin
      @(negedge clk);
      wd++;
      out_ready = ($urandom_range(0, 3) != 0);
      if (out_valid && out_ready) begin
        int e;
        e = exp_bits(got, n);
        check(int'(out_idx) == got, {"R9 index order ", tag}, out_idx, got);
        if (got == LA || got == LB)
          check(int'(out_bits) == e, {"R7 link entry ", tag}, out_bits, e);
        else
          check(int'(out_bits) == e, {"R6 bit count ", tag}, out_bits, e);
        check(out_last == (got == NUM_SC-1), {"R9 last flag ", tag}, out_last, got == NUM_SC-1);
        got++;
      end
    end
    @(negedge clk);
    out_ready = 0;
    @(negedge clk);
    check(out_valid === 1'b0 && done === 1'b1, {"R8 single pass, done held ", tag}, out_valid, 0);
    check(got == NUM_SC, {"R9 entry count ", tag}, got, NUM_SC);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(busy === 0 && done === 0 && bin_ready === 0 && out_valid === 0, "R1 reset quiet", busy, 0);
    rst_n = 1;
    @(negedge clk);
    check(busy === 0 && done === 0 && bin_ready === 0 && out_valid === 0, "R1 after release", done, 0);

    // squares of 50,40,30,20,10,4
    write_thr(0, 2500); write_thr(1, 1600); write_thr(2, 900);
    write_thr(3, 400);  write_thr(4, 100);  write_thr(5, 16);
    write_thr(6, 0);    // R6 select 6 dropped; model unchanged

    // R10: bins offered while idle are ignored
    @(negedge clk);
    bin_valid = 1; bin_idx = 0; bin_i = 10'h1ff; bin_q = 10'h1ff;
    repeat (4) @(negedge clk);
    check(bin_ready === 1'b0, "R10 ready low when idle", bin_ready, 0);
    bin_valid = 0;

    run(0, 1, 0, "directed N0");        // R6 equality boundaries, R4 pilot
    run(2, 0, 0, "random N2");          // R5 averaging
    // R10: bins offered while done
    @(negedge clk);
    bin_valid = 1; bin_idx = 2; bin_i = 10'h100; bin_q = 10'h100;
    repeat (4) @(negedge clk);
    check(bin_ready === 1'b0, "R10 ready low when done", bin_ready, 0);
    bin_valid = 0;
    run(1, 0, 1, "start mid-run R3");   // R2 clearing, R3
    run(7, 0, 0, "clamp N7");           // R5 clamp to 6
    write_thr(0, 3000); write_thr(3, 300);
    run(3, 1, 0, "directed N3 new thr");
    run(0, 0, 0, "random N0");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule